// File: doc/BRIEF.md
# Decoder Interrupt Status Controller

This block merges five event sources from an audio stream decoder into one interrupt request line toward the processor. Three of the sources are error events: a checksum failure, a loss of frame synchronisation and an unsupported layer. The decoder reports each one as a single-cycle pulse. The block latches each of these into a sticky flag, and software acknowledges them by reading the status register. The other two sources are level conditions: the decoder wants more input data, or ancillary data is waiting. Their flags follow the decoder's level inputs directly. A status read never clears them. They drop only when the condition goes away.

Software reaches three byte-wide registers through a simple read and write port: the status register, a control register holding one mask bit per source, and an enable register holding a peripheral enable and a global enable. A read returns data in the same cycle. The clear side effect of a status read takes effect at the clock edge that ends that cycle. The request output is the OR of all unmasked flags, and it is passed on only while both enable bits are set.

Top module: `dec_irq_status`

## Requirements
- R1: After reset the three error flags, all five mask bits and both enable bits are 0, and the request output is 0.
- R2: A pulse on errPulse[2] (checksum), errPulse[1] (sync) or errPulse[0] (layer) sets status bit 7, 6 or 5 respectively from the next clock edge, and the flag stays set until a status read.
- R3: A status read (address 0) returns the current flags, and at the end of that cycle it clears status bits 7, 6 and 5.
- R4: If an error pulse arrives in the same cycle as a status read, the read returns the old value of that flag and the flag is set afterwards.
- R5: Status bit 4 equals the dataReq input and status bit 3 equals the ancAvail input at all times, and a status read leaves both unchanged.
- R6: Status bits 2 to 0 always read as 0, and a write to the status address changes no register.
- R7: The control register (address 1) holds the mask bits in bits 4 to 0; control bit k masks status bit k+3; control bits 7 to 5 read as 0.
- R8: The request output is 1 exactly when some status flag is 1 with its mask bit 0, and the peripheral enable and the global enable are both 1. A mask bit of 1 blocks its source.
- R9: The enable register (address 2) holds the peripheral enable in bit 5 and the global enable in bit 7. Its other bits read as 0. Address 3, and any cycle without a read, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| rdEn | input | 1 | Read strobe; data returned in the same cycle |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data |
| errPulse | input | 3 | Error event pulses: [2] checksum, [1] sync, [0] layer |
| dataReq | input | 1 | Decoder requests more input data (level) |
| ancAvail | input | 1 | Ancillary data pending (level) |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: an 8-bit data width, flags starting at status bit 3, and the enables at bits 5 and 7. These are the bit positions software relies on, so each register's field placement and reserved zero bits can be checked directly at the read port. With these values, every mask and enable combination in the vector table and the same-cycle read and event collision can be reached.

// File: rtl/dec_irq_pkg.sv
package dec_irq_pkg;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_ENABLE = 2'd3
  } read_sel_e;

  typedef struct packed {
    logic      statusRead;
    logic      ctrlWrite;
    logic      enableWrite;
    read_sel_e readSel;
  } strobe_t;

endpackage

// File: rtl/dec_irq_ctrl.sv
module dec_irq_ctrl
  import dec_irq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int STATUS_ADDR = 0,
  parameter int CTRL_ADDR   = 1,
  parameter int ENABLE_ADDR = 2
) (
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] StatusA = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] CtrlA   = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] EnableA = ADDR_W'(ENABLE_ADDR);

  always_comb begin
    strb.statusRead  = rdEn && (addr == StatusA);
    strb.ctrlWrite   = wrEn && (addr == CtrlA);
    strb.enableWrite = wrEn && (addr == EnableA);
    strb.readSel     = SEL_NONE;
    if (rdEn) begin
      if (addr == StatusA)      strb.readSel = SEL_STATUS;
      else if (addr == CtrlA)   strb.readSel = SEL_CTRL;
      else if (addr == EnableA) strb.readSel = SEL_ENABLE;
    end
  end

endmodule

// File: rtl/dec_irq_dp.sv
module dec_irq_dp
  import dec_irq_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int NUM_ERR       = 3,
  parameter int NUM_LVL       = 2,
  parameter int STATUS_LSB    = 3,
  parameter int PERIPH_EN_BIT = 5,
  parameter int GLOBAL_EN_BIT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_ERR-1:0] errPulse,
  input  logic [NUM_LVL-1:0] lvlIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);

  localparam int NumSrc = NUM_ERR + NUM_LVL;

  logic [NUM_ERR-1:0] errFlags;
  logic [NumSrc-1:0]  maskReg;
  logic               periphEn;
  logic               globalEn;
  logic [NumSrc-1:0]  srcVec;
  logic [DATA_W-1:0]  statusWord;
  logic [DATA_W-1:0]  ctrlWord;
  logic [DATA_W-1:0]  enableWord;

  // Sticky error flags: a read clears, a same-cycle event wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlags <= '0;
    else       errFlags <= (strb.statusRead ? '0 : errFlags) | errPulse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg  <= '0;
      periphEn <= 1'b0;
      globalEn <= 1'b0;
    end else begin
      if (strb.ctrlWrite) maskReg <= wrData[NumSrc-1:0];
      if (strb.enableWrite) begin
        periphEn <= wrData[PERIPH_EN_BIT];
        globalEn <= wrData[GLOBAL_EN_BIT];
      end
    end
  end

  assign srcVec = {errFlags, lvlIn};

  always_comb begin
    statusWord = '0;
    statusWord[STATUS_LSB +: NumSrc] = srcVec;
    ctrlWord = '0;
    ctrlWord[NumSrc-1:0] = maskReg;
    enableWord = '0;
    enableWord[PERIPH_EN_BIT] = periphEn;
    enableWord[GLOBAL_EN_BIT] = globalEn;
  end

  always_comb begin
    case (strb.readSel)
      SEL_STATUS: rdData = statusWord;
      SEL_CTRL:   rdData = ctrlWord;
      SEL_ENABLE: rdData = enableWord;
      default:    rdData = '0;
    endcase
  end

  assign irq = (|(srcVec & ~maskReg)) & periphEn & globalEn;

  wire unusedWrBits = ^wrData;

  // R2: without a read, no error flag falls
  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statusRead |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  // R3: a read with no new event leaves all error flags clear
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusRead && errPulse == '0) |=> (errFlags == '0));

  // R4: every event pulse is captured, even under a read
  assert_event_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse != '0) |=> ((errFlags & $past(errPulse)) == $past(errPulse)));

  // R6: reserved low status bits read zero
  assert_status_low_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readSel == SEL_STATUS) |-> (rdData[STATUS_LSB-1:0] == '0));

  // R8: a request needs both enables
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (periphEn && globalEn));

endmodule

// File: rtl/dec_irq_status.sv
module dec_irq_status
  import dec_irq_pkg::*;
#(
  parameter int ADDR_W        = 2,
  parameter int DATA_W        = 8,
  parameter int NUM_ERR       = 3,
  parameter int NUM_LVL       = 2,
  parameter int STATUS_LSB    = 3,
  parameter int PERIPH_EN_BIT = 5,
  parameter int GLOBAL_EN_BIT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_ERR-1:0] errPulse,
  input  logic               dataReq,
  input  logic               ancAvail,
  output logic               irq
);

  strobe_t strb;

  dec_irq_ctrl #(
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .rdEn (rdEn),
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  dec_irq_dp #(
    .DATA_W       (DATA_W),
    .NUM_ERR      (NUM_ERR),
    .NUM_LVL      (NUM_LVL),
    .STATUS_LSB   (STATUS_LSB),
    .PERIPH_EN_BIT(PERIPH_EN_BIT),
    .GLOBAL_EN_BIT(GLOBAL_EN_BIT)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .errPulse (errPulse),
    .lvlIn    ({dataReq, ancAvail}),
    .rdData   (rdData),
    .irq      (irq)
  );

endmodule

// File: tb/tb_dec_irq_status.sv
module tb_dec_irq_status;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = '0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [2:0] errPulse = '0;
  logic       dataReq = 1'b0;
  logic       ancAvail = 1'b0;
  logic       irq;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dec_irq_status dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .errPulse(errPulse),
    .dataReq(dataReq), .ancAvail(ancAvail), .irq(irq)
  );

  // {err[2:0], dataReq, ancAvail, mask[4:0], enable[7:0], expIrq}
  localparam logic [18:0] Vecs [8] = '{
    {3'b100, 1'b0, 1'b0, 5'b00000, 8'hA0, 1'b1},
    {3'b100, 1'b0, 1'b0, 5'b10000, 8'hA0, 1'b0},
    {3'b010, 1'b0, 1'b0, 5'b10000, 8'hA0, 1'b1},
    {3'b001, 1'b0, 1'b0, 5'b00000, 8'h20, 1'b0},
    {3'b000, 1'b1, 1'b0, 5'b00000, 8'h80, 1'b0},
    {3'b000, 1'b1, 1'b0, 5'b00010, 8'hA0, 1'b0},
    {3'b000, 1'b0, 1'b1, 5'b00010, 8'hA0, 1'b1},
    {3'b000, 1'b0, 1'b0, 5'b00000, 8'hA0, 1'b0}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic pulseErr(input logic [2:0] e);
    @(negedge clk);
    errPulse = e;
    @(posedge clk); #1;
    errPulse = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] expStat;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    #1 chk({7'd0, irq}, 8'h00, "R1 irq after reset");
    busRead(2'd0, d); chk(d, 8'h00, "R1 status after reset");
    busRead(2'd1, d); chk(d, 8'h00, "R1 control after reset");
    busRead(2'd2, d); chk(d, 8'h00, "R1 enable after reset");

    // Vector table: R2 R3 R5 R8
    foreach (Vecs[i]) begin
      logic [2:0] e; logic dr; logic an; logic [4:0] m; logic [7:0] en; logic ex;
      {e, dr, an, m, en, ex} = Vecs[i];
      busWrite(2'd1, {3'b000, m});
      busWrite(2'd2, en);
      @(negedge clk); dataReq = dr; ancAvail = an;
      pulseErr(e);
      chk({7'd0, irq}, {7'd0, ex}, $sformatf("R8 irq vector %0d", i));
      expStat = {e, dr, an, 3'b000};
      busRead(2'd0, d); chk(d, expStat, $sformatf("R2 status vector %0d", i));
      busRead(2'd0, d); chk(d, {3'b000, dr, an, 3'b000}, $sformatf("R3 R5 cleared vector %0d", i));
    end
    @(negedge clk); dataReq = 1'b0; ancAvail = 1'b0;

    // R2 sticky across idle cycles
    pulseErr(3'b001);
    repeat (5) @(posedge clk);
    busRead(2'd0, d); chk(d, 8'h20, "R2 layer flag held");

    // R4 event and read in the same cycle
    @(negedge clk);
    addr = 2'd0; rdEn = 1'b1; errPulse = 3'b010;
    #1 chk(rdData, 8'h00, "R4 read returns old value");
    @(posedge clk); #1;
    rdEn = 1'b0; errPulse = '0;
    busRead(2'd0, d); chk(d, 8'h40, "R4 flag set after collision");

    // R5 level flags survive reads
    @(negedge clk); dataReq = 1'b1; ancAvail = 1'b1;
    busRead(2'd0, d);
    busRead(2'd0, d); chk(d, 8'h18, "R5 level flags after read");
    @(negedge clk); dataReq = 1'b0;
    #1 busRead(2'd0, d); chk(d, 8'h08, "R5 data request follows input");
    @(negedge clk); ancAvail = 1'b0;

    // R6 writes to status ignored
    busWrite(2'd1, 8'h00);
    busWrite(2'd2, 8'h00);
    busWrite(2'd0, 8'hFF);
    busRead(2'd0, d); chk(d, 8'h00, "R6 status write ignored");
    busRead(2'd1, d); chk(d, 8'h00, "R6 control untouched");
    busRead(2'd2, d); chk(d, 8'h00, "R6 enable untouched");

    // R7 control readback
    busWrite(2'd1, 8'hFF);
    busRead(2'd1, d); chk(d, 8'h1F, "R7 control upper bits zero");

    // R9 enable readback and unused address
    busWrite(2'd2, 8'hFF);
    busRead(2'd2, d); chk(d, 8'hA0, "R9 enable bits");
    busRead(2'd3, d); chk(d, 8'h00, "R9 unused address");
    @(negedge clk); addr = 2'd1;
    #1 chk(rdData, 8'h00, "R9 no read returns zero");

    // R8 all masked with both enables: no request
    pulseErr(3'b111);
    chk({7'd0, irq}, 8'h00, "R8 all masked");
    busWrite(2'd1, 8'h1B);
    chk({7'd0, irq}, 8'h01, "R8 layer unmasked");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule